// File: doc/BRIEF.md
# Receive Byte DMA Channel

This block empties a serial receiver's one-byte data holding register into memory with no processor work per byte. Each time the receiver presents a byte, the channel latches it and raises a data-full flag. While the channel is enabled, a full flag becomes a request to an external bus arbiter. When the arbiter acknowledges, the channel does three things in that same cycle. It writes the byte through a single-cycle memory port at the current pointer, advances the pointer, and lowers the remaining-transfer count.

Software loads a 16-bit start pointer and a 16-bit transfer count while the channel is off, then sets the enable bit. When the last counted byte has been written, the channel sets a sticky end-of-block flag, which drives an interrupt, and it turns its own enable off. If a second byte arrives before the first has been moved, an overrun is flagged and only the newest byte is kept.

Top module: `rx_byte_dma`

## Requirements
- R1: `dma_req` is high exactly when a byte is held (`rx_full`=1) and `dma_en`=1. Once raised, it stays high until `dma_ack` is seen or software turns the channel off.
- R2: In a cycle with `dma_req` and `dma_ack` both high, `mem_we`=1, `mem_addr` is the current pointer and `mem_wdata` is the held byte. `mem_we` is 0 in every other cycle.
- R3: After each transfer, the pointer is one higher, wrapping from 0xFFFF to 0x0000, and `dma_remain` is one lower.
- R4: A transfer clears `rx_full`. If `rx_load` occurs in the same cycle as the transfer, `rx_full` stays 1, the new byte is held for the next transfer, and no overrun is flagged.
- R5: A transfer made while `dma_remain`=1 sets `eob_irq` and clears `dma_en`, so a later byte raises no request.
- R6: Writing enable=1 while `dma_remain`=0 sets `eob_irq`, leaves `dma_en`=0 and makes no request.
- R7: Writing enable=0 drops the request at once. Pointer and count writes made while `dma_en`=1 are ignored.
- R8: `eob_irq` stays set until a `sw_eob_clr` pulse. A set in the same cycle as a clear wins.
- R9: An `rx_load` while `rx_full`=1 and no transfer is under way sets the sticky `rx_overrun` flag and replaces the held byte. `sw_ovr_clr` clears the flag.
- R10: After reset, all flags, the enable bit, the pointer and the count are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_load | input | 1 | Receiver presents a new byte this cycle |
| rx_data | input | 8 | Received byte |
| sw_en_wr | input | 1 | Software write strobe for the enable bit |
| sw_en_val | input | 1 | Enable value written |
| sw_addr_wr | input | 1 | Pointer load strobe (honoured only when disabled) |
| sw_addr_val | input | 16 | Pointer load value |
| sw_cnt_wr | input | 1 | Count load strobe (honoured only when disabled) |
| sw_cnt_val | input | 16 | Count load value |
| sw_eob_clr | input | 1 | Write-one clear of the end-of-block flag |
| sw_ovr_clr | input | 1 | Write-one clear of the overrun flag |
| dma_ack | input | 1 | Arbiter grant |
| dma_req | output | 1 | Transfer request to the arbiter |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Write address, equal to the current pointer |
| mem_wdata | output | 8 | Write data |
| dma_remain | output | 16 | Remaining transfer count |
| dma_en | output | 1 | Channel enable bit |
| rx_full | output | 1 | A received byte is waiting |
| rx_overrun | output | 1 | Sticky overrun flag |
| eob_irq | output | 1 | Sticky end-of-block pending, used as interrupt |

## Verification
Two pairs of events can land in one cycle. The first pair is a grant and a fresh byte from the receiver. The bench drives `dma_ack` and `rx_load` together and expects the old byte on the write port, `rx_full` still set afterwards, no overrun, and the new byte on the next transfer. The second pair is the terminal transfer and a software clear of the end-of-block flag, which the bench also drives together; the flag must end up set.

// File: rtl/rxdma_pkg.sv
package rxdma_pkg;
  localparam int AW = 16;
  localparam int CW = 16;
  localparam int DW = 8;

  function automatic logic [AW-1:0] ptr_next(input logic [AW-1:0] a);
    return a + AW'(1);
  endfunction

  function automatic logic [CW-1:0] cnt_next(input logic [CW-1:0] c);
    return c - CW'(1);
  endfunction

  function automatic logic cnt_is_last(input logic [CW-1:0] c);
    return c == CW'(1);
  endfunction

  function automatic logic cnt_is_empty(input logic [CW-1:0] c);
    return c == '0;
  endfunction
endpackage

// File: rtl/rxdma_buf.sv
module rxdma_buf
  import rxdma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_data,
  input  logic          take,
  input  logic          ovr_clr,
  output logic          full,
  output logic          ovr,
  output logic [DW-1:0] byte_q
);
  logic ovr_set;
  assign ovr_set = rx_load && full && !take;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full   <= 1'b0;
      ovr    <= 1'b0;
      byte_q <= '0;
    end else begin
      if (rx_load) begin
        byte_q <= rx_data;
        full   <= 1'b1;
      end else if (take) begin
        full <= 1'b0;
      end
      ovr <= ovr_set || (ovr && !ovr_clr);
    end
  end

  // R4
  full_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && !rx_load |=> !full);
  // R4
  collide_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take && rx_load && !ovr |=> full && !ovr);
  // R9
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load && full && !take |=> ovr);
endmodule

// File: rtl/rxdma_ptr.sv
module rxdma_ptr
  import rxdma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          fire,
  input  logic          en_wr,
  input  logic          en_val,
  input  logic          addr_wr,
  input  logic [AW-1:0] addr_val,
  input  logic          cnt_wr,
  input  logic [CW-1:0] cnt_val,
  input  logic          eob_clr,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] cnt,
  output logic          en,
  output logic          eob,
  output logic          last_xfer,
  output logic          zero_arm
);
  logic eob_set;

  assign last_xfer = fire && cnt_is_last(cnt);
  assign zero_arm  = en_wr && en_val && cnt_is_empty(cnt);
  assign eob_set   = last_xfer || zero_arm;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr <= '0;
      cnt  <= '0;
      en   <= 1'b0;
      eob  <= 1'b0;
    end else begin
      if (fire) begin
        addr <= ptr_next(addr);
        cnt  <= cnt_next(cnt);
      end else begin
        if (addr_wr && !en) addr <= addr_val;
        if (cnt_wr && !en)  cnt  <= cnt_val;
      end
      if (last_xfer)  en <= 1'b0;
      else if (en_wr) en <= en_val && !cnt_is_empty(cnt);
      eob <= eob_set || (eob && !eob_clr);
    end
  end

  // R3
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> addr == ptr_next($past(addr)) && cnt == cnt_next($past(cnt)));
  // R5
  term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_xfer |=> eob && !en);
  // R6
  zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_arm && !fire |=> eob && !en);
  // R8
  eob_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eob && !eob_clr |=> eob);
  // R7
  load_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en && !fire |=> $stable(addr) && $stable(cnt));
endmodule

// File: rtl/rx_byte_dma.sv
module rx_byte_dma
  import rxdma_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rx_load,
  input  logic [DW-1:0] rx_data,
  input  logic          sw_en_wr,
  input  logic          sw_en_val,
  input  logic          sw_addr_wr,
  input  logic [AW-1:0] sw_addr_val,
  input  logic          sw_cnt_wr,
  input  logic [CW-1:0] sw_cnt_val,
  input  logic          sw_eob_clr,
  input  logic          sw_ovr_clr,
  input  logic          dma_ack,
  output logic          dma_req,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  output logic [CW-1:0] dma_remain,
  output logic          dma_en,
  output logic          rx_full,
  output logic          rx_overrun,
  output logic          eob_irq
);
  logic fire;
  logic last_xfer;
  logic zero_arm;

  assign dma_req = rx_full && dma_en;
  assign fire    = dma_req && dma_ack;
  assign mem_we  = fire;

  rxdma_buf u_buf (
    .clk(clk), .rst_n(rst_n), .rx_load(rx_load), .rx_data(rx_data),
    .take(fire), .ovr_clr(sw_ovr_clr), .full(rx_full), .ovr(rx_overrun),
    .byte_q(mem_wdata)
  );

  rxdma_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .fire(fire),
    .en_wr(sw_en_wr), .en_val(sw_en_val),
    .addr_wr(sw_addr_wr), .addr_val(sw_addr_val),
    .cnt_wr(sw_cnt_wr), .cnt_val(sw_cnt_val),
    .eob_clr(sw_eob_clr),
    .addr(mem_addr), .cnt(dma_remain), .en(dma_en), .eob(eob_irq),
    .last_xfer(last_xfer), .zero_arm(zero_arm)
  );

  // R1
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dma_req && !dma_ack && !sw_en_wr |=> dma_req);
  // R2
  we_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> dma_en && rx_full);
  // R5
  post_term_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_xfer && !sw_en_wr |=> !dma_req);
endmodule

// File: tb/sim_rx_byte_dma.sv
`timescale 1ns/1ps
module sim_rx_byte_dma;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_load = 0, sw_en_wr = 0, sw_en_val = 0, sw_addr_wr = 0;
  logic        sw_cnt_wr = 0, sw_eob_clr = 0, sw_ovr_clr = 0, dma_ack = 0;
  logic [7:0]  rx_data = 0;
  logic [15:0] sw_addr_val = 0, sw_cnt_val = 0;
  logic        dma_req, mem_we, dma_en, rx_full, rx_overrun, eob_irq;
  logic [15:0] mem_addr, dma_remain;
  logic [7:0]  mem_wdata;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rx_byte_dma u0 (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    rx_load = 0; sw_en_wr = 0; sw_addr_wr = 0; sw_cnt_wr = 0;
    sw_eob_clr = 0; sw_ovr_clr = 0; dma_ack = 0;
  endtask

  task automatic tick();
    @(negedge clk);
    idle_inputs();
    #1;
  endtask

  task automatic rx_byte(logic [7:0] b);
    rx_load = 1; rx_data = b; tick();
  endtask

  task automatic t_reset();
    chk("R10 req", dma_req, 0);
    chk("R10 en", dma_en, 0);
    chk("R10 flags", {rx_full, rx_overrun, eob_irq}, 0);
    chk("R10 addr", mem_addr, 0);
    chk("R10 remain", dma_remain, 0);
  endtask

  task automatic t_zero();
    sw_en_wr = 1; sw_en_val = 1; tick();
    chk("R6 eob", eob_irq, 1);
    chk("R6 en", dma_en, 0);
    chk("R6 req", dma_req, 0);
    sw_eob_clr = 1; tick();
    chk("R8 clear", eob_irq, 0);
  endtask

  task automatic t_basic();
    sw_addr_wr = 1; sw_addr_val = 16'h1000; sw_cnt_wr = 1; sw_cnt_val = 3; tick();
    sw_en_wr = 1; sw_en_val = 1; tick();
    chk("R1 no byte no req", dma_req, 0);
    rx_byte(8'hA5);
    chk("R1 req", dma_req, 1);
    tick(); tick();
    chk("R1 held", dma_req, 1);
    dma_ack = 1; #1;
    chk("R2 we", mem_we, 1);
    chk("R2 addr", mem_addr, 16'h1000);
    chk("R2 data", mem_wdata, 8'hA5);
    tick();
    chk("R4 full cleared", rx_full, 0);
    chk("R2 we low", mem_we, 0);
    chk("R3 addr", mem_addr, 16'h1001);
    chk("R3 remain", dma_remain, 2);
  endtask

  task automatic t_collide();
    rx_byte(8'h3C);
    dma_ack = 1; rx_load = 1; rx_data = 8'h7E; #1;
    chk("R4 old byte out", mem_wdata, 8'h3C);
    tick();
    chk("R4 still full", rx_full, 1);
    chk("R4 no overrun", rx_overrun, 0);
    chk("R4 new byte held", mem_wdata, 8'h7E);
  endtask

  task automatic t_ignore();
    sw_addr_wr = 1; sw_addr_val = 16'h2222; sw_cnt_wr = 1; sw_cnt_val = 9; tick();
    chk("R7 addr locked", mem_addr, 16'h1002);
    chk("R7 count locked", dma_remain, 1);
  endtask

  task automatic t_terminal();
    dma_ack = 1; #1;
    chk("R2 last addr", mem_addr, 16'h1002);
    tick();
    chk("R5 eob", eob_irq, 1);
    chk("R5 en off", dma_en, 0);
    rx_byte(8'h11);
    chk("R5 no req", dma_req, 0);
    tick(); tick();
    chk("R8 sticky", eob_irq, 1);
    sw_eob_clr = 1; tick();
    chk("R8 cleared", eob_irq, 0);
  endtask

  task automatic t_overrun();
    rx_byte(8'h22);
    chk("R9 overrun", rx_overrun, 1);
    sw_addr_wr = 1; sw_addr_val = 16'hFFFF; sw_cnt_wr = 1; sw_cnt_val = 2; tick();
    sw_en_wr = 1; sw_en_val = 1; tick();
    dma_ack = 1; #1;
    chk("R9 newest byte", mem_wdata, 8'h22);
    tick();
    chk("R3 wrap", mem_addr, 16'h0000);
    chk("R3 remain", dma_remain, 1);
    sw_ovr_clr = 1; tick();
    chk("R9 cleared", rx_overrun, 0);
  endtask

  task automatic t_disable();
    rx_byte(8'h33);
    chk("R1 req", dma_req, 1);
    sw_en_wr = 1; sw_en_val = 0; tick();
    chk("R7 req dropped", dma_req, 0);
    chk("R7 addr kept", mem_addr, 16'h0000);
  endtask

  task automatic t_setclr();
    sw_en_wr = 1; sw_en_val = 1; tick();
    dma_ack = 1; sw_eob_clr = 1; tick();
    chk("R8 set wins", eob_irq, 1);
    chk("R5 en off", dma_en, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    t_reset();
    t_zero();
    t_basic();
    t_collide();
    t_ignore();
    t_terminal();
    t_overrun();
    t_disable();
    t_setclr();
    finish_run();
  end

  initial begin
    repeat (5000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    finish_run();
  end
endmodule